// File: doc/BRIEF.md
# Brown-out Reset Qualifier and Recovery Sequencer

This block turns a raw undervoltage flag from a supply comparator into a clean brown-out reset. The flag is first brought into the clock domain through a two-stage synchronizer. It is then counted, and a brown-out is declared only once the flag has stayed high for a programmable number of consecutive clock ticks. Shorter dips are dropped, and any gap in the flag sends the count back to zero.

After a brown-out is declared, the reset output stays high for as long as the supply stays low. When the supply recovers, an internal power-up delay keeps the reset high for a further programmable number of ticks. At the start of each delay, a one-cycle restart pulse goes to the downstream power-up timer. If the undervoltage flag comes back during the delay, even for a single cycle, the block goes back to holding. The delay then starts again from zero at the next recovery, so such dips are not filtered. A sticky status bit records that a brown-out has occurred, and a software write clears it. A configuration enable, treated as synchronous, switches the whole function off.

Top module: `bor_ctrl`

## Requirements
- R1: While `bor_en` is 0, `bor_rst` is 0, `pwrt_restart` is 0 and `bor_flag` is not set, whatever `uv_in` does. If `bor_en` falls while reset is held, `bor_rst` is 0 after the next clock edge.
- R2: If `uv_in` is sampled 1 at QUAL_TICKS or more consecutive rising edges, starting at edge e0, then `bor_rst` is 1 after edge e0+QUAL_TICKS+2.
- R3: If `uv_in` is 1 for fewer than QUAL_TICKS consecutive edges, no reset follows. The count restarts from zero on any low sample, so two short pulses separated by one low cycle do not add together.
- R4: Once a brown-out is qualified, `bor_rst` stays 1 for every cycle in which the synchronized flag is high.
- R5: If `uv_in` is first sampled 0 at edge f0 while reset is held, the delay starts at edge f0+2. `bor_rst` stays 1 for exactly DELAY_TICKS further edges and is 0 after edge f0+2+DELAY_TICKS.
- R6: Any return of `uv_in`, even for one cycle, during the delay keeps `bor_rst` at 1 and re-enters holding. The full DELAY_TICKS delay then starts again after the next recovery.
- R7: `pwrt_restart` is a single-cycle pulse. It is 1 in the cycle after each start of the power-up delay and is 0 at all other times.
- R8: `bor_flag` becomes 1 in the same cycle that `bor_rst` rises. It stays 1 until `flag_clr` is sampled 1. A new brown-out in the same cycle as a clear leaves the flag at 1.
- R9: A synchronous active-high `rst` drives `bor_rst`, `pwrt_restart` and `bor_flag` to 0 and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bor_en | input | 1 | Brown-out function enable (configuration) |
| uv_in | input | 1 | Asynchronous undervoltage flag from comparator |
| flag_clr | input | 1 | Software clear of the status bit |
| bor_rst | output | 1 | Brown-out reset level, registered |
| pwrt_restart | output | 1 | One-cycle restart pulse to the power-up timer |
| bor_flag | output | 1 | Sticky status bit: brown-out occurred |

## Verification
The bench drives pulses of exactly QUAL_TICKS and QUAL_TICKS-1 cycles. A design whose qualification count is off by one would reset on the short pulse or miss the exact one. It also drives two short pulses with a one-cycle gap between them, which catches a count that fails to clear on a low sample. One-cycle dips during the power-up delay expose a design that filters these dips or resumes the old delay count instead of restarting it. The bench also checks the exact release edge, which moves if a register is missing or added. Randomized bursts, enable drops and clears that collide with a new brown-out are compared every cycle against a reference model kept in the bench.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DELAY = 2'd2
  } bor_state_t;
endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bor_qualifier.sv
module bor_qualifier #(
  parameter int QUAL_TICKS = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uv_s,
  output logic qual
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_TICKS);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !uv_s) run_cnt <= '0;
    else if (run_cnt != QMAX) run_cnt <= run_cnt + 1'b1;
  end

  assign qual = (run_cnt == QMAX);

  // R3: a low sample always restarts the run count
  a_r3_count_clears: assert property (@(posedge clk) disable iff (rst)
    !uv_s |=> (run_cnt == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= QMAX);
endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer
  import bor_pkg::*;
#(
  parameter int DELAY_TICKS = 3600000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uv_s,
  input  logic qual,
  output logic rst_out,
  output logic restart,
  output logic trip
);
  localparam int DW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DELAY_TICKS - 1);

  bor_state_t state, nxt;
  logic [DW-1:0] dly_cnt;

  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (qual) nxt = ST_HOLD;
        ST_HOLD:  if (!uv_s) nxt = ST_DELAY;
        ST_DELAY: begin
          if (uv_s) nxt = ST_HOLD;
          else if (dly_cnt == DLAST) nxt = ST_IDLE;
        end
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  assign trip = (state == ST_IDLE) && (nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      dly_cnt <= '0;
      rst_out <= 1'b0;
      restart <= 1'b0;
    end else begin
      state   <= nxt;
      rst_out <= (nxt != ST_IDLE);
      restart <= (state == ST_HOLD) && (nxt == ST_DELAY);
      if (state != ST_DELAY || nxt != ST_DELAY) dly_cnt <= '0;
      else dly_cnt <= dly_cnt + 1'b1;
    end
  end

  // R4: holding with the supply still low keeps reset asserted
  a_r4_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_HOLD && uv_s) |=> rst_out);

  // R1: disabled means reset released on the next edge
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rst_out && state == ST_IDLE));

  // R7: restart never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart);

  // R6: undervoltage during the delay goes back to holding
  a_r6_dip_rearms: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_DELAY && uv_s) |=> (state == ST_HOLD && rst_out));

  // R5: the delay counter stays in range
  a_r5_delay_bound: assert property (@(posedge clk) disable iff (rst)
    dly_cnt <= DLAST);
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl #(
  parameter int QUAL_TICKS  = 5000,
  parameter int DELAY_TICKS = 3600000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bor_en,
  input  logic uv_in,
  input  logic flag_clr,
  output logic bor_rst,
  output logic pwrt_restart,
  output logic bor_flag
);
  logic uv_s;
  logic qual;
  logic trip;

  bor_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(uv_in), .q(uv_s)
  );

  bor_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst(rst), .en(bor_en), .uv_s(uv_s), .qual(qual)
  );

  bor_sequencer #(.DELAY_TICKS(DELAY_TICKS)) u_seq (
    .clk(clk), .rst(rst), .en(bor_en), .uv_s(uv_s), .qual(qual),
    .rst_out(bor_rst), .restart(pwrt_restart), .trip(trip)
  );

  always_ff @(posedge clk) begin
    if (rst)           bor_flag <= 1'b0;
    else if (trip)     bor_flag <= 1'b1;
    else if (flag_clr) bor_flag <= 1'b0;
  end

  // R8: the status bit is set whenever reset rises
  a_r8_flag_on_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(bor_rst) |-> bor_flag);

  // R8: without a clear the status bit is sticky
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (bor_flag && !flag_clr) |=> bor_flag);
endmodule

// File: tb/bor_ctrl_test.sv
module bor_ctrl_test;
  localparam int Q = 6;
  localparam int D = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bor_en = 1'b0;
  logic uv_in = 1'b0;
  logic flag_clr = 1'b0;
  logic bor_rst, pwrt_restart, bor_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bor_ctrl #(.QUAL_TICKS(Q), .DELAY_TICKS(D), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bor_en(bor_en), .uv_in(uv_in),
    .flag_clr(flag_clr), .bor_rst(bor_rst), .pwrt_restart(pwrt_restart),
    .bor_flag(bor_flag)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_rst, m_pulse, m_flag;
  int   m_cnt, m_dcnt, m_state; // 0 idle, 1 hold, 2 delay

  always @(posedge clk) begin
    bit trip_now;
    trip_now = 1'b0;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_cnt <= 0; m_dcnt <= 0; m_state <= 0;
      m_rst <= 0; m_pulse <= 0; m_flag <= 0;
    end else begin
      m_s1 <= uv_in;
      m_s2 <= m_s1;
      if (!bor_en || !m_s2) m_cnt <= 0;
      else if (m_cnt < Q) m_cnt <= m_cnt + 1;
      m_pulse <= 0;
      if (!bor_en) begin
        m_state <= 0; m_rst <= 0; m_dcnt <= 0;
      end else if (m_state == 0) begin
        if (m_cnt >= Q) begin m_state <= 1; m_rst <= 1; trip_now = 1'b1; end
      end else if (m_state == 1) begin
        if (!m_s2) begin m_state <= 2; m_dcnt <= 0; m_pulse <= 1; end
      end else begin
        if (m_s2) m_state <= 1;
        else if (m_dcnt == D - 1) begin m_state <= 0; m_rst <= 0; m_dcnt <= 0; end
        else m_dcnt <= m_dcnt + 1;
      end
      if (trip_now) m_flag <= 1;
      else if (flag_clr) m_flag <= 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      if (!rst) begin
        check("R2 R4 R5 bor_rst vs model", bor_rst, m_rst);
        check("R7 pwrt_restart vs model", pwrt_restart, m_pulse);
        check("R8 bor_flag vs model", bor_flag, m_flag);
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    bor_en = 1'b1; uv_in = 1'b1; flag_clr = 1'b1;
    step(3);
    // R9: reset state
    check("R9 reset bor_rst", bor_rst, 1'b0);
    check("R9 reset pulse", pwrt_restart, 1'b0);
    check("R9 reset flag", bor_flag, 1'b0);
    rst = 1'b0; uv_in = 1'b0; flag_clr = 1'b0; bor_en = 1'b0;
    step(4);

    // R1: disabled, long undervoltage
    uv_in = 1'b1;
    step(Q + 10);
    check("R1 disabled no reset", bor_rst, 1'b0);
    check("R1 disabled no flag", bor_flag, 1'b0);
    uv_in = 1'b0;
    step(4);
    bor_en = 1'b1;
    step(2);

    // R3: short pulse
    uv_in = 1'b1; step(Q - 1); uv_in = 1'b0;
    step(Q + 4);
    check("R3 short pulse ignored", bor_rst, 1'b0);
    // R3: two short pulses one low cycle apart
    uv_in = 1'b1; step(Q - 1); uv_in = 1'b0; step(1);
    uv_in = 1'b1; step(Q - 1); uv_in = 1'b0;
    step(Q + 4);
    check("R3 split pulses do not add", bor_rst, 1'b0);
    check("R3 no flag", bor_flag, 1'b0);

    // R2: exact-length pulse and exact timing
    uv_in = 1'b1; step(Q); uv_in = 1'b0;
    step(2);
    check("R2 not yet at e0+Q+1", bor_rst, 1'b0);
    step(1);
    check("R2 reset after e0+Q+2", bor_rst, 1'b1);
    check("R8 flag with reset", bor_flag, 1'b1);
    step(1);
    check("R7 pulse at delay start", pwrt_restart, 1'b1);
    step(D - 1);
    check("R5 still held at end of delay", bor_rst, 1'b1);
    step(1);
    check("R5 released after delay", bor_rst, 1'b0);

    // R8: clear
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R8 flag cleared", bor_flag, 1'b0);

    // R4, R6: long hold, then one-cycle dip during delay
    uv_in = 1'b1; step(Q + 20);
    check("R4 held during undervoltage", bor_rst, 1'b1);
    uv_in = 1'b0; step(D / 2);
    uv_in = 1'b1; step(1); uv_in = 1'b0;
    step(D);
    check("R6 dip restarts delay", bor_rst, 1'b1);
    step(8);
    check("R6 released after fresh delay", bor_rst, 1'b0);

    // R8: clear collides with new trip
    uv_in = 1'b1; step(Q + 2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R8 trip beats clear", bor_flag, 1'b1);

    // R1: enable drop while holding
    step(3);
    bor_en = 1'b0; step(1);
    check("R1 enable drop releases", bor_rst, 1'b0);
    uv_in = 1'b0; step(4);
    bor_en = 1'b1; step(2);

    // random bursts against the model
    for (int b = 0; b < 300; b++) begin
      uv_in = 1'b1;
      step($urandom_range(1, Q + 5));
      uv_in = 1'b0;
      step($urandom_range(1, D + 8));
      flag_clr = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) bor_en = ~bor_en;
      step(1);
      flag_clr = 1'b0;
    end
    bor_en = 1'b1;
    step(D + 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule